// File: doc/BRIEF.md
# Directory DMA Read Serializer

This block is the home directory controller for a small table of cache lines. It tracks, for each line, a coherence state, the owning node and a bitmap of sharers. Each cycle it takes at most one request from the request queue and one message from the response/unblock queue. For each request it does exactly one of three things: it answers from the directory, it forwards the request to the current owner, or it recycles the request back to the tail of the request queue.

A DMA read to a line that has an owner is forwarded to that owner. The line then stays blocked until the owner's DMA acknowledgement comes back on the response queue. While it is blocked, no later request to the line can overtake the read in flight. When a line is only shared, or not cached at all, the directory supplies the data itself. A DMA write to an owned or modified line is forwarded with the directory marked as requestor, invalidates the sharers, and parks the line until the owner's data returns. Every outcome is registered and appears on the outputs in the cycle after the input was presented.

Top module: `dir_dma_serializer`

## Requirements
- R1: After reset every line is invalid and all output valids are low. A DMA read to any line then gets a data answer from the directory, with ack count 0.
- R2: Each request produces exactly one of forward, answer (data, writeback-ack or nack) or recycle, registered and visible one clock after the request is presented. Encodings: request type GETS=0, GETX=1, PUTX=2, PUTO=3, DMA read=4, DMA write=5. Response type DMA ack=0, data=1. Answer kind data=0, writeback-ack=1, nack=2. Requestor class cache=0, DMA=1.
- R3: A DMA read to a shared line is answered by the directory with data and ack count 0, nothing is forwarded, and the line stays shared.
- R4: A DMA read to an owned line is forwarded to the owner, with the owner as a one-hot set, and the line enters the owned-wait state. A DMA ack on the response queue returns it to owned.
- R5: A DMA read to a modified line is forwarded to the owner and the line enters the modified-wait state. A DMA ack returns it to modified.
- R6: In either wait state, every request type to that line is recycled with its type, line, requestor and class echoed. No other output fires and the line state is unchanged.
- R7: A DMA write to an owned or modified line is forwarded with the directory-as-requestor flag set. It invalidates all sharers, and the line recycles every request until a data response arrives, which makes the line invalid.
- R8: A forwarded request carries the original requestor's class. Its ack count is the number of sharers, excluding the requestor when the requestor is a cache that is itself a sharer.
- R9: A DMA ack arriving in any state other than the two wait states raises a one-cycle error pulse and leaves the line state unchanged.
- R10: A data response to a line that is not awaiting owner data raises the error pulse.
- R11: When the request and the response target the same line in the same cycle, the response is handled and the request is recycled.
- R12: In invalid or shared, GETS adds the requestor as a sharer and GETX makes it the owner. Both are answered with data. GETX from shared invalidates the other sharers and reports their count as the answer's ack count.
- R13: GETS to a modified line is forwarded and the line becomes owned. A PUT from the owner gets a writeback-ack and releases ownership. A PUT from a non-owner gets a nack.
- R14: A line blocked in a wait state does not hold up requests to other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request queue head valid |
| reqType | input | 3 | Request type |
| reqLine | input | LINE_W | Line index of request |
| reqSrc | input | NODE_W | Requestor node id |
| reqClass | input | 1 | Requestor class (0 cache, 1 DMA) |
| rspValid | input | 1 | Response queue head valid (always consumed) |
| rspType | input | 1 | Response type |
| rspLine | input | LINE_W | Line index of response |
| fwdValid | output | 1 | Forwarded request valid |
| fwdType | output | 3 | Forwarded request type |
| fwdLine | output | LINE_W | Forwarded line |
| fwdSrc | output | NODE_W | Original requestor id |
| fwdClass | output | 1 | Original requestor class |
| fwdDirIsReq | output | 1 | Directory stands as requestor |
| fwdOwners | output | NUM_NODES | Owner set, one-hot |
| fwdAcks | output | ACK_W | Sharer ack count |
| invValid | output | 1 | Invalidation valid |
| invLine | output | LINE_W | Invalidated line |
| invTargets | output | NUM_NODES | Nodes to invalidate |
| ansValid | output | 1 | Directory answer valid |
| ansKind | output | 2 | Answer kind |
| ansLine | output | LINE_W | Answered line |
| ansDest | output | NODE_W | Answer destination |
| ansAcks | output | ACK_W | Acks the destination must collect |
| recValid | output | 1 | Recycle push valid |
| recType | output | 3 | Recycled request type |
| recLine | output | LINE_W | Recycled line |
| recSrc | output | NODE_W | Recycled requestor |
| recClass | output | 1 | Recycled class |
| protoErr | output | 1 | Unexpected response pulse |

## Verification
The hardest situation to reach is a request and a DMA ack colliding on one line in the same cycle, while the line is already back in the owned state. The stimulus first builds up an owner and two sharers through ordinary reads. It then parks the line in owned-wait with a DMA read, releases it, and only then presents a GETS and a stray ack together. All six request types are also driven into a waiting line, while a neighbour line keeps receiving service.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [2:0] {
    REQ_GETS  = 3'd0,
    REQ_GETX  = 3'd1,
    REQ_PUTX  = 3'd2,
    REQ_PUTO  = 3'd3,
    REQ_DMARD = 3'd4,
    REQ_DMAWR = 3'd5
  } req_kind_e;

  typedef enum logic {
    RSP_DMA_ACK = 1'b0,
    RSP_DATA    = 1'b1
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ANS_DATA  = 2'd0,
    ANS_WBACK = 2'd1,
    ANS_NACK  = 2'd2
  } ans_kind_e;

  typedef enum logic {
    CLS_CACHE = 1'b0,
    CLS_DMA   = 1'b1
  } req_class_e;

  typedef enum logic [2:0] {
    LS_I      = 3'd0,
    LS_S      = 3'd1,
    LS_O      = 3'd2,
    LS_M      = 3'd3,
    LS_OWAIT  = 3'd4,
    LS_MWAIT  = 3'd5,
    LS_OIDATA = 3'd6
  } line_state_e;

  typedef struct packed {
    logic        reqWr;
    line_state_e reqNext;
    logic        ownToReq;
    logic        ownClr;
    logic        shAddReq;
    logic        shClr;
    logic        rspWr;
    line_state_e rspNext;
    logic        rspClrAll;
    logic        doFwd;
    logic        fwdDirReq;
    logic        doInv;
    logic        doAns;
    ans_kind_e   ansKind;
    logic        ansWithAcks;
    logic        doRecycle;
    logic        doErr;
  } dir_strobe_t;

endpackage

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  req_kind_e   reqKind,
  input  line_state_e reqState,
  input  logic        reqIsOwner,
  input  logic        reqShAny,
  input  logic        rspValid,
  input  rsp_kind_e   rspKind,
  input  line_state_e rspState,
  input  logic        sameLine,
  output dir_strobe_t stb
);

  always_comb begin
    stb = '0;
    // response / unblock queue: always consumed in its cycle
    if (rspValid) begin
      unique case (rspKind)
        RSP_DMA_ACK: begin
          if (rspState == LS_OWAIT) begin
            stb.rspWr   = 1'b1;
            stb.rspNext = LS_O;
          end else if (rspState == LS_MWAIT) begin
            stb.rspWr   = 1'b1;
            stb.rspNext = LS_M;
          end else begin
            stb.doErr = 1'b1;
          end
        end
        default: begin
          if (rspState == LS_OIDATA) begin
            stb.rspWr     = 1'b1;
            stb.rspNext   = LS_I;
            stb.rspClrAll = 1'b1;
          end else begin
            stb.doErr = 1'b1;
          end
        end
      endcase
    end

    if (reqValid) begin
      if (rspValid && sameLine) begin
        stb.doRecycle = 1'b1;
      end else begin
        unique case (reqState)
          LS_I: begin
            unique case (reqKind)
              REQ_GETS: begin
                stb.reqWr = 1'b1; stb.reqNext = LS_S; stb.shAddReq = 1'b1;
                stb.doAns = 1'b1; stb.ansKind = ANS_DATA;
              end
              REQ_GETX: begin
                stb.reqWr = 1'b1; stb.reqNext = LS_M; stb.ownToReq = 1'b1;
                stb.doAns = 1'b1; stb.ansKind = ANS_DATA;
              end
              REQ_DMARD: begin
                stb.doAns = 1'b1; stb.ansKind = ANS_DATA;
              end
              REQ_DMAWR: begin
                stb.doAns = 1'b1; stb.ansKind = ANS_WBACK;
              end
              default: begin
                stb.doAns = 1'b1; stb.ansKind = ANS_NACK;
              end
            endcase
          end
          LS_S: begin
            unique case (reqKind)
              REQ_GETS: begin
                stb.reqWr = 1'b1; stb.reqNext = LS_S; stb.shAddReq = 1'b1;
                stb.doAns = 1'b1; stb.ansKind = ANS_DATA;
              end
              REQ_GETX: begin
                stb.reqWr = 1'b1; stb.reqNext = LS_M; stb.ownToReq = 1'b1;
                stb.shClr = 1'b1; stb.doInv = 1'b1;
                stb.doAns = 1'b1; stb.ansKind = ANS_DATA; stb.ansWithAcks = 1'b1;
              end
              REQ_DMARD: begin
                stb.doAns = 1'b1; stb.ansKind = ANS_DATA;
              end
              REQ_DMAWR: begin
                stb.reqWr = 1'b1; stb.reqNext = LS_I; stb.shClr = 1'b1;
                stb.doInv = 1'b1;
                stb.doAns = 1'b1; stb.ansKind = ANS_WBACK; stb.ansWithAcks = 1'b1;
              end
              default: begin
                stb.doAns = 1'b1; stb.ansKind = ANS_NACK;
              end
            endcase
          end
          LS_O: begin
            unique case (reqKind)
              REQ_GETS: begin
                stb.doFwd = 1'b1;
                stb.reqWr = 1'b1; stb.reqNext = LS_O; stb.shAddReq = 1'b1;
              end
              REQ_GETX: begin
                stb.doFwd = 1'b1; stb.doInv = 1'b1;
                stb.reqWr = 1'b1; stb.reqNext = LS_M;
                stb.ownToReq = 1'b1; stb.shClr = 1'b1;
              end
              REQ_PUTX, REQ_PUTO: begin
                stb.doAns = 1'b1;
                if (reqIsOwner) begin
                  stb.ansKind = ANS_WBACK;
                  stb.reqWr = 1'b1; stb.ownClr = 1'b1;
                  stb.reqNext = reqShAny ? LS_S : LS_I;
                end else begin
                  stb.ansKind = ANS_NACK;
                end
              end
              REQ_DMARD: begin
                stb.doFwd = 1'b1;
                stb.reqWr = 1'b1; stb.reqNext = LS_OWAIT;
              end
              REQ_DMAWR: begin
                stb.doFwd = 1'b1; stb.fwdDirReq = 1'b1; stb.doInv = 1'b1;
                stb.reqWr = 1'b1; stb.reqNext = LS_OIDATA; stb.shClr = 1'b1;
              end
              default: begin
                stb.doAns = 1'b1; stb.ansKind = ANS_NACK;
              end
            endcase
          end
          LS_M: begin
            unique case (reqKind)
              REQ_GETS: begin
                stb.doFwd = 1'b1;
                stb.reqWr = 1'b1; stb.reqNext = LS_O; stb.shAddReq = 1'b1;
              end
              REQ_GETX: begin
                stb.doFwd = 1'b1;
                stb.reqWr = 1'b1; stb.reqNext = LS_M; stb.ownToReq = 1'b1;
              end
              REQ_PUTX, REQ_PUTO: begin
                stb.doAns = 1'b1;
                if (reqIsOwner) begin
                  stb.ansKind = ANS_WBACK;
                  stb.reqWr = 1'b1; stb.reqNext = LS_I; stb.ownClr = 1'b1;
                end else begin
                  stb.ansKind = ANS_NACK;
                end
              end
              REQ_DMARD: begin
                stb.doFwd = 1'b1;
                stb.reqWr = 1'b1; stb.reqNext = LS_MWAIT;
              end
              REQ_DMAWR: begin
                stb.doFwd = 1'b1; stb.fwdDirReq = 1'b1; stb.doInv = 1'b1;
                stb.reqWr = 1'b1; stb.reqNext = LS_OIDATA; stb.shClr = 1'b1;
              end
              default: begin
                stb.doAns = 1'b1; stb.ansKind = ANS_NACK;
              end
            endcase
          end
          default: begin
            stb.doRecycle = 1'b1;
          end
        endcase
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({stb.doFwd, stb.doAns, stb.doRecycle}) == 1) // R2
    else $error("request without exactly one outcome");

  AST_ERR_FROM_RSP: assert property (@(posedge clk) disable iff (!rstN)
    stb.doErr |-> rspValid) // R9
    else $error("error raised without a response");

  AST_WAIT_NO_REQ_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqState == LS_OWAIT || reqState == LS_MWAIT)) |-> !stb.reqWr) // R6
    else $error("request altered a waiting line");

endmodule

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int NUM_LINES = 8,
  localparam int NODE_W = $clog2(NUM_NODES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int ACK_W  = $clog2(NUM_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dir_strobe_t          stb,
  input  logic [2:0]           reqType,
  input  logic [LINE_W-1:0]    reqLine,
  input  logic [NODE_W-1:0]    reqSrc,
  input  logic                 reqClass,
  input  logic [LINE_W-1:0]    rspLine,
  output line_state_e          reqState,
  output logic                 reqIsOwner,
  output logic                 reqShAny,
  output line_state_e          rspState,
  output logic                 fwdValid,
  output logic [2:0]           fwdType,
  output logic [LINE_W-1:0]    fwdLine,
  output logic [NODE_W-1:0]    fwdSrc,
  output logic                 fwdClass,
  output logic                 fwdDirIsReq,
  output logic [NUM_NODES-1:0] fwdOwners,
  output logic [ACK_W-1:0]     fwdAcks,
  output logic                 invValid,
  output logic [LINE_W-1:0]    invLine,
  output logic [NUM_NODES-1:0] invTargets,
  output logic                 ansValid,
  output logic [1:0]           ansKind,
  output logic [LINE_W-1:0]    ansLine,
  output logic [NODE_W-1:0]    ansDest,
  output logic [ACK_W-1:0]     ansAcks,
  output logic                 recValid,
  output logic [2:0]           recType,
  output logic [LINE_W-1:0]    recLine,
  output logic [NODE_W-1:0]    recSrc,
  output logic                 recClass,
  output logic                 protoErr
);

  line_state_e                           stAll [NUM_LINES];
  logic [NUM_LINES-1:0][NUM_NODES-1:0]   ownAll;
  logic [NUM_LINES-1:0][NUM_NODES-1:0]   shAll;

  logic [NUM_NODES-1:0] srcHot;
  logic [NUM_NODES-1:0] reqOwn;
  logic [NUM_NODES-1:0] reqSh;
  logic [NUM_NODES-1:0] shExcl;
  logic [ACK_W-1:0]     shCnt;

  assign srcHot     = NUM_NODES'(1) << reqSrc;
  assign reqOwn     = ownAll[reqLine];
  assign reqSh      = shAll[reqLine];
  assign shExcl     = reqSh & ~((reqClass == CLS_CACHE) ? srcHot : '0);
  assign shCnt      = ACK_W'($countones(shExcl));
  assign reqState   = stAll[reqLine];
  assign rspState   = stAll[rspLine];
  assign reqIsOwner = (reqClass == CLS_CACHE) && ((reqOwn & srcHot) != '0);
  assign reqShAny   = (reqSh != '0);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    line_state_e          stQ;
    logic [NUM_NODES-1:0] ownQ;
    logic [NUM_NODES-1:0] shQ;
    logic                 rspHit;
    logic                 reqHit;

    assign rspHit = stb.rspWr && (rspLine == LINE_W'(g));
    assign reqHit = stb.reqWr && (reqLine == LINE_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ  <= LS_I;
        ownQ <= '0;
        shQ  <= '0;
      end else if (rspHit) begin
        stQ <= stb.rspNext;
        if (stb.rspClrAll) begin
          ownQ <= '0;
          shQ  <= '0;
        end
      end else if (reqHit) begin
        stQ <= stb.reqNext;
        if (stb.ownToReq)    ownQ <= srcHot;
        else if (stb.ownClr) ownQ <= '0;
        if (stb.shClr)         shQ <= '0;
        else if (stb.shAddReq) shQ <= shQ | srcHot;
      end
    end

    assign stAll[g]  = stQ;
    assign ownAll[g] = ownQ;
    assign shAll[g]  = shQ;

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      ((stQ == LS_OWAIT || stQ == LS_MWAIT) && !rspHit) |=> $stable(stQ)) // R6
      else $error("waiting line left its state without an ack");

    AST_ACK_RETURNS_OWNED: assert property (@(posedge clk) disable iff (!rstN)
      (stQ == LS_OWAIT && rspHit) |=> stQ == LS_O) // R4
      else $error("owned-wait did not return to owned");

    AST_ACK_RETURNS_MOD: assert property (@(posedge clk) disable iff (!rstN)
      (stQ == LS_MWAIT && rspHit) |=> stQ == LS_M) // R5
      else $error("modified-wait did not return to modified");
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0; fwdType <= '0; fwdLine <= '0; fwdSrc <= '0;
      fwdClass <= 1'b0; fwdDirIsReq <= 1'b0; fwdOwners <= '0; fwdAcks <= '0;
      invValid <= 1'b0; invLine <= '0; invTargets <= '0;
      ansValid <= 1'b0; ansKind <= '0; ansLine <= '0; ansDest <= '0; ansAcks <= '0;
      recValid <= 1'b0; recType <= '0; recLine <= '0; recSrc <= '0; recClass <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      fwdValid    <= stb.doFwd;
      fwdType     <= stb.doFwd ? reqType : '0;
      fwdLine     <= stb.doFwd ? reqLine : '0;
      fwdSrc      <= stb.doFwd ? reqSrc : '0;
      fwdClass    <= stb.doFwd && reqClass;
      fwdDirIsReq <= stb.doFwd && stb.fwdDirReq;
      fwdOwners   <= stb.doFwd ? reqOwn : '0;
      fwdAcks     <= stb.doFwd ? shCnt : '0;

      invValid    <= stb.doInv && (shExcl != '0);
      invLine     <= (stb.doInv && (shExcl != '0)) ? reqLine : '0;
      invTargets  <= stb.doInv ? shExcl : '0;

      ansValid    <= stb.doAns;
      ansKind     <= stb.doAns ? stb.ansKind : ANS_DATA;
      ansLine     <= stb.doAns ? reqLine : '0;
      ansDest     <= stb.doAns ? reqSrc : '0;
      ansAcks     <= (stb.doAns && stb.ansWithAcks) ? shCnt : '0;

      recValid    <= stb.doRecycle;
      recType     <= stb.doRecycle ? reqType : '0;
      recLine     <= stb.doRecycle ? reqLine : '0;
      recSrc      <= stb.doRecycle ? reqSrc : '0;
      recClass    <= stb.doRecycle && reqClass;

      protoErr    <= stb.doErr;
    end
  end

  AST_RECYCLE_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> !(fwdValid || ansValid || invValid)) // R6
    else $error("recycle together with another outcome");

  AST_DIRREQ_ONLY_DMAWR: assert property (@(posedge clk) disable iff (!rstN)
    fwdDirIsReq |-> (fwdValid && fwdType == REQ_DMAWR)) // R7
    else $error("directory-as-requestor on a non DMA write");

  AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> $countones(fwdOwners) == 1) // R4
    else $error("forward without a single owner");

endmodule

// File: rtl/dir_dma_serializer.sv
module dir_dma_serializer
  import dir_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int NUM_LINES = 8,
  localparam int NODE_W = $clog2(NUM_NODES),
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int ACK_W  = $clog2(NUM_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [2:0]           reqType,
  input  logic [LINE_W-1:0]    reqLine,
  input  logic [NODE_W-1:0]    reqSrc,
  input  logic                 reqClass,
  input  logic                 rspValid,
  input  logic                 rspType,
  input  logic [LINE_W-1:0]    rspLine,
  output logic                 fwdValid,
  output logic [2:0]           fwdType,
  output logic [LINE_W-1:0]    fwdLine,
  output logic [NODE_W-1:0]    fwdSrc,
  output logic                 fwdClass,
  output logic                 fwdDirIsReq,
  output logic [NUM_NODES-1:0] fwdOwners,
  output logic [ACK_W-1:0]     fwdAcks,
  output logic                 invValid,
  output logic [LINE_W-1:0]    invLine,
  output logic [NUM_NODES-1:0] invTargets,
  output logic                 ansValid,
  output logic [1:0]           ansKind,
  output logic [LINE_W-1:0]    ansLine,
  output logic [NODE_W-1:0]    ansDest,
  output logic [ACK_W-1:0]     ansAcks,
  output logic                 recValid,
  output logic [2:0]           recType,
  output logic [LINE_W-1:0]    recLine,
  output logic [NODE_W-1:0]    recSrc,
  output logic                 recClass,
  output logic                 protoErr
);

  dir_strobe_t stb;
  line_state_e reqState;
  line_state_e rspState;
  logic        reqIsOwner;
  logic        reqShAny;

  dir_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (req_kind_e'(reqType)),
    .reqState   (reqState),
    .reqIsOwner (reqIsOwner),
    .reqShAny   (reqShAny),
    .rspValid   (rspValid),
    .rspKind    (rsp_kind_e'(rspType)),
    .rspState   (rspState),
    .sameLine   (reqLine == rspLine),
    .stb        (stb)
  );

  dir_datapath #(
    .NUM_NODES (NUM_NODES),
    .NUM_LINES (NUM_LINES)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqType     (reqType),
    .reqLine     (reqLine),
    .reqSrc      (reqSrc),
    .reqClass    (reqClass),
    .rspLine     (rspLine),
    .reqState    (reqState),
    .reqIsOwner  (reqIsOwner),
    .reqShAny    (reqShAny),
    .rspState    (rspState),
    .fwdValid    (fwdValid),
    .fwdType     (fwdType),
    .fwdLine     (fwdLine),
    .fwdSrc      (fwdSrc),
    .fwdClass    (fwdClass),
    .fwdDirIsReq (fwdDirIsReq),
    .fwdOwners   (fwdOwners),
    .fwdAcks     (fwdAcks),
    .invValid    (invValid),
    .invLine     (invLine),
    .invTargets  (invTargets),
    .ansValid    (ansValid),
    .ansKind     (ansKind),
    .ansLine     (ansLine),
    .ansDest     (ansDest),
    .ansAcks     (ansAcks),
    .recValid    (recValid),
    .recType     (recType),
    .recLine     (recLine),
    .recSrc      (recSrc),
    .recClass    (recClass),
    .protoErr    (protoErr)
  );

endmodule

// File: tb/dir_dma_serializer_test.sv
module dir_dma_serializer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqType = '0;
  logic [2:0] reqLine = '0;
  logic [1:0] reqSrc = '0;
  logic       reqClass = 1'b0;
  logic       rspValid = 1'b0;
  logic       rspType = 1'b0;
  logic [2:0] rspLine = '0;

  logic       fwdValid, fwdClass, fwdDirIsReq, invValid, ansValid, recValid, recClass, protoErr;
  logic [2:0] fwdType, fwdLine, fwdAcks, invLine, ansLine, ansAcks, recType, recLine;
  logic [1:0] fwdSrc, ansKind, ansDest, recSrc;
  logic [3:0] fwdOwners, invTargets;

  typedef struct packed {
    logic fv; logic [2:0] ft; logic [2:0] fa; logic [1:0] fr; logic fc; logic fd;
    logic [3:0] fo; logic [2:0] fk;
    logic iv; logic [2:0] ia; logic [3:0] it;
    logic av; logic [1:0] ak; logic [2:0] aa; logic [1:0] ad; logic [2:0] ac;
    logic cv; logic [2:0] ct; logic [2:0] ca; logic [1:0] cr; logic cc;
    logic er;
  } obs_t;

  obs_t  expQ [$];
  string tagQ [$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_dma_serializer uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqType(reqType), .reqLine(reqLine), .reqSrc(reqSrc), .reqClass(reqClass),
    .rspValid(rspValid), .rspType(rspType), .rspLine(rspLine),
    .fwdValid(fwdValid), .fwdType(fwdType), .fwdLine(fwdLine), .fwdSrc(fwdSrc), .fwdClass(fwdClass),
    .fwdDirIsReq(fwdDirIsReq), .fwdOwners(fwdOwners), .fwdAcks(fwdAcks),
    .invValid(invValid), .invLine(invLine), .invTargets(invTargets),
    .ansValid(ansValid), .ansKind(ansKind), .ansLine(ansLine), .ansDest(ansDest), .ansAcks(ansAcks),
    .recValid(recValid), .recType(recType), .recLine(recLine), .recSrc(recSrc), .recClass(recClass),
    .protoErr(protoErr)
  );

  function automatic obs_t oNone();
    return '0;
  endfunction

  function automatic obs_t oFwd(logic [2:0] t, logic [2:0] a, logic [1:0] r, logic c, logic d,
                                logic [3:0] o, logic [2:0] k);
    obs_t e = '0;
    e.fv = 1'b1; e.ft = t; e.fa = a; e.fr = r; e.fc = c; e.fd = d; e.fo = o; e.fk = k;
    return e;
  endfunction

  function automatic obs_t oInv(logic [2:0] a, logic [3:0] tg);
    obs_t e = '0;
    e.iv = 1'b1; e.ia = a; e.it = tg;
    return e;
  endfunction

  function automatic obs_t oAns(logic [1:0] k, logic [2:0] a, logic [1:0] d, logic [2:0] n);
    obs_t e = '0;
    e.av = 1'b1; e.ak = k; e.aa = a; e.ad = d; e.ac = n;
    return e;
  endfunction

  function automatic obs_t oRec(logic [2:0] t, logic [2:0] a, logic [1:0] r, logic c);
    obs_t e = '0;
    e.cv = 1'b1; e.ct = t; e.ca = a; e.cr = r; e.cc = c;
    return e;
  endfunction

  function automatic obs_t oErr();
    obs_t e = '0;
    e.er = 1'b1;
    return e;
  endfunction

  // driver: present one cycle of stimulus and queue the expected outputs
  task automatic step(input logic rv, input logic [2:0] rt, input logic [2:0] rl,
                      input logic [1:0] rs, input logic rc,
                      input logic pv, input logic pt, input logic [2:0] pl,
                      input obs_t e, input string tag);
    @(negedge clk);
    reqValid = rv; reqType = rt; reqLine = rl; reqSrc = rs; reqClass = rc;
    rspValid = pv; rspType = pt; rspLine = pl;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic req(input logic [2:0] rt, input logic [2:0] rl, input logic [1:0] rs,
                     input logic rc, input obs_t e, input string tag);
    step(1'b1, rt, rl, rs, rc, 1'b0, 1'b0, 3'd0, e, tag);
  endtask

  task automatic rsp(input logic pt, input logic [2:0] pl, input obs_t e, input string tag);
    step(1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b1, pt, pl, e, tag);
  endtask

  // monitor: compare registered outputs just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        obs_t  act;
        obs_t  exp;
        string tag;
        act = {fwdValid, fwdType, fwdLine, fwdSrc, fwdClass, fwdDirIsReq, fwdOwners, fwdAcks,
               invValid, invLine, invTargets,
               ansValid, ansKind, ansLine, ansDest, ansAcks,
               recValid, recType, recLine, recSrc, recClass, protoErr};
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        nChecks++;
        if (act !== exp) begin
          nFails++;
          $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  localparam logic [2:0] GETS = 3'd0, GETX = 3'd1, PUTX = 3'd2, PUTO = 3'd3, DRD = 3'd4, DWR = 3'd5;
  localparam logic ACK = 1'b0, DAT = 1'b1;
  localparam logic [1:0] A_DATA = 2'd0, A_WBACK = 2'd1, A_NACK = 2'd2;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, oNone(), "R1 reset idle");
    req(DRD, 3'd1, 2'd3, 1'b1, oAns(A_DATA, 3'd1, 2'd3, 3'd0), "R1 R2 dma read of invalid line");
    req(GETS, 3'd2, 2'd0, 1'b0, oAns(A_DATA, 3'd2, 2'd0, 3'd0), "R12 gets invalid");
    req(GETS, 3'd2, 2'd1, 1'b0, oAns(A_DATA, 3'd2, 2'd1, 3'd0), "R12 gets shared");
    req(DRD, 3'd2, 2'd2, 1'b1, oAns(A_DATA, 3'd2, 2'd2, 3'd0), "R3 dma read shared");
    req(GETS, 3'd2, 2'd2, 1'b0, oAns(A_DATA, 3'd2, 2'd2, 3'd0), "R3 still shared");
    req(GETX, 3'd2, 2'd0, 1'b0, oInv(3'd2, 4'b0110) | oAns(A_DATA, 3'd2, 2'd0, 3'd2),
        "R12 getx from shared");
    req(GETS, 3'd2, 2'd1, 1'b0, oFwd(GETS, 3'd2, 2'd1, 1'b0, 1'b0, 4'b0001, 3'd0),
        "R13 gets to modified");
    req(DRD, 3'd2, 2'd3, 1'b1, oFwd(DRD, 3'd2, 2'd3, 1'b1, 1'b0, 4'b0001, 3'd1),
        "R4 R8 dma read to owned");
    req(GETS, 3'd2, 2'd1, 1'b0, oRec(GETS, 3'd2, 2'd1, 1'b0), "R6 gets recycled");
    req(GETX, 3'd2, 2'd2, 1'b0, oRec(GETX, 3'd2, 2'd2, 1'b0), "R6 getx recycled");
    req(PUTX, 3'd2, 2'd0, 1'b0, oRec(PUTX, 3'd2, 2'd0, 1'b0), "R6 putx recycled");
    req(PUTO, 3'd2, 2'd0, 1'b0, oRec(PUTO, 3'd2, 2'd0, 1'b0), "R6 puto recycled");
    req(DRD, 3'd2, 2'd1, 1'b1, oRec(DRD, 3'd2, 2'd1, 1'b1), "R6 dma read recycled");
    req(DWR, 3'd2, 2'd1, 1'b1, oRec(DWR, 3'd2, 2'd1, 1'b1), "R6 dma write recycled");
    req(GETS, 3'd3, 2'd3, 1'b0, oAns(A_DATA, 3'd3, 2'd3, 3'd0), "R14 other line served");
    rsp(ACK, 3'd2, oNone(), "R4 dma ack consumed");
    req(GETS, 3'd2, 2'd2, 1'b0, oFwd(GETS, 3'd2, 2'd2, 1'b0, 1'b0, 4'b0001, 3'd1),
        "R4 back in owned");
    step(1'b1, GETS, 3'd2, 2'd3, 1'b0, 1'b1, ACK, 3'd2, oRec(GETS, 3'd2, 2'd3, 1'b0) | oErr(),
         "R11 R9 collision with stray ack");
    req(DWR, 3'd2, 2'd3, 1'b1,
        oFwd(DWR, 3'd2, 2'd3, 1'b1, 1'b1, 4'b0001, 3'd2) | oInv(3'd2, 4'b0110),
        "R7 R8 dma write to owned");
    req(GETS, 3'd2, 2'd1, 1'b0, oRec(GETS, 3'd2, 2'd1, 1'b0), "R7 recycled awaiting data");
    rsp(DAT, 3'd2, oNone(), "R7 owner data");
    req(GETS, 3'd2, 2'd1, 1'b0, oAns(A_DATA, 3'd2, 2'd1, 3'd0), "R7 line invalid after data");
    req(GETX, 3'd4, 2'd1, 1'b0, oAns(A_DATA, 3'd4, 2'd1, 3'd0), "R12 getx invalid");
    req(DRD, 3'd4, 2'd0, 1'b1, oFwd(DRD, 3'd4, 2'd0, 1'b1, 1'b0, 4'b0010, 3'd0),
        "R5 dma read to modified");
    req(DRD, 3'd4, 2'd2, 1'b1, oRec(DRD, 3'd4, 2'd2, 1'b1), "R6 modified-wait recycles");
    rsp(ACK, 3'd4, oNone(), "R5 dma ack consumed");
    req(GETX, 3'd4, 2'd2, 1'b0, oFwd(GETX, 3'd4, 2'd2, 1'b0, 1'b0, 4'b0010, 3'd0),
        "R5 back in modified");
    req(PUTX, 3'd4, 2'd1, 1'b0, oAns(A_NACK, 3'd4, 2'd1, 3'd0), "R13 put from non-owner");
    req(PUTX, 3'd4, 2'd2, 1'b0, oAns(A_WBACK, 3'd4, 2'd2, 3'd0), "R13 put from owner");
    req(DRD, 3'd4, 2'd0, 1'b1, oAns(A_DATA, 3'd4, 2'd0, 3'd0), "R13 released to invalid");
    req(GETX, 3'd5, 2'd3, 1'b0, oAns(A_DATA, 3'd5, 2'd3, 3'd0), "R12 getx invalid line5");
    req(DWR, 3'd5, 2'd1, 1'b1, oFwd(DWR, 3'd5, 2'd1, 1'b1, 1'b1, 4'b1000, 3'd0),
        "R7 dma write to modified");
    rsp(DAT, 3'd5, oNone(), "R7 owner data line5");
    rsp(DAT, 3'd5, oErr(), "R10 unexpected data");
    rsp(ACK, 3'd6, oErr(), "R9 ack to invalid line");
    req(DRD, 3'd6, 2'd0, 1'b1, oAns(A_DATA, 3'd6, 2'd0, 3'd0), "R9 state unchanged");
    step(1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, oNone(), "R2 idle after traffic");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule